// File: doc/BRIEF.md
# Polyphase Azimuth Decimating Pre-Filter

This block thins out radar echo data along the slow-time axis and leaves the fast-time (range) axis untouched. Complex baseband samples arrive one per beat, tagged with a range-bin index. A start-of-pulse strobe marks the first sample of each new pulse. For every range bin on its own, the block runs a finite-impulse-response filter across the samples of successive pulses and keeps one result in M. M is chosen at run time. The filter works entirely in the time domain, which keeps both storage and memory traffic small.

The filter is built from four weighted integrate-and-dump accumulators per range bin. Each accumulator covers a window of 4M pulses, and their start points are spaced M pulses apart, so exactly one of them completes a window every M pulses. Each pulse is weighted from a 128-point taper. That taper is tuned for the largest M and is read at a coarser stride for smaller M. A completed sum is rounded, saturated back to the input width and sent out together with its range bin.

Top module: `azpf_top`

## Requirements
- R1: The decimation code `dec_sel` selects M = 2 << dec_sel for codes 0 to 4, giving 2, 4, 8, 16 and 32. Codes 5, 6 and 7 behave exactly like code 4.
- R2: A pulse begins on a beat with `in_valid` and `in_sop` both high, and every valid beat belongs to the most recently begun pulse. Each range bin is accumulated on its own, and `out_bin` equals the `in_bin` of the sample that completed the result.
- R3: Counting pulses from 0 after a restart, phase j (0 to 3) begins a window at every pulse whose index p satisfies (p − j·M) mod 4M = 0. The window spans 4M pulses and dumps on its last pulse. After warm-up this yields one output per range bin every M pulses.
- R4: A sample at position n (0 to 4M−1) within a window is multiplied by weight w(k) = floor(k·(127−k)/4), where k = n·(32/M). The window sum is the sum of the weight times the sample, taken separately for I and for Q.
- R5: An output equals floor((S + 2^(s−1)) / 2^s) with s = 11 + code (the effective code, 0 to 4), saturated to the signed range of the input width, applied to I and Q separately.
- R6: A phase produces no output until it has begun a full window after the latest restart, so the first output appears on pulse 4M−1.
- R7: A change in the effective code takes effect only on a start-of-pulse beat, where it restarts all phases at pulse 0. A change of `dec_sel` in the middle of a pulse does not affect that pulse. A new value that maps to the same effective code causes no restart.
- R8: While `rst_n` is low, `out_valid` is low on the following cycle. The first start of pulse after reset is a restart.
- R9: A result appears on the outputs exactly three clock cycles after the clock edge that captured the sample that completed it.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_sel | input | 3 | Decimation code, read on start-of-pulse beats |
| in_valid | input | 1 | Sample present this beat |
| in_sop | input | 1 | First sample of a new pulse |
| in_bin | input | $clog2(NB) | Range-bin index of the sample |
| in_i | input | DW | In-phase sample, signed |
| in_q | input | DW | Quadrature sample, signed |
| out_valid | output | 1 | Decimated result present |
| out_bin | output | $clog2(NB) | Range bin of the result |
| out_i | output | DW | In-phase result, signed |
| out_q | output | DW | Quadrature result, signed |

## Verification
The bench targets warm-up suppression at every M. A design that dumped early would emit lines from half-filled windows before pulse 4M−1. It also runs full-scale constant inputs through the gain above one to exercise saturation at both rails, where a design without clamping would wrap in sign. Code changes are tested in three ways: mid-pulse, between pulses, and to a value that aliases to the current code. A wrong restart rule would shift or drop output lines, which shows up as out-of-order or missing bins and values. A reset in the middle of traffic checks that stale accumulator contents never leak into the next window.

// File: rtl/azpf_pkg.sv
// Shared constants and helpers for the azimuth pre-filter.
// Assumes: four phases, a 128-point taper, decimation codes 0..4.
package azpf_pkg;
    localparam int NPH      = 4;      // overlapping integrate-and-dump phases
    localparam int KW       = 7;      // taper index / pulse position width
    localparam int NTAP     = 1 << KW;
    localparam int CODE_MAX = 4;      // code for M = 32

    // Map any 3-bit decimation code onto 0..CODE_MAX.
    function automatic logic [2:0] clamp_code(input logic [2:0] c);
        return (c > 3'(CODE_MAX)) ? 3'(CODE_MAX) : c;
    endfunction

    // Parabolic taper value for index k in 0..127.
    function automatic int unsigned taper(input int unsigned k);
        return (k * (127 - k)) / 4;
    endfunction
endpackage

// File: rtl/azpf_pulse_ctrl.sv
// Pulse bookkeeping: tracks the active decimation code, the pulse index
// modulo 4M and the warm-up state of every phase. For the current beat it
// gives each phase its taper index, a window-start flag and a dump flag.
// Assumes: a pulse opens on in_valid && in_sop; all outputs are combinational
// views of the beat in progress.
module azpf_pulse_ctrl
    import azpf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sop,
    input  logic [2:0]               dec_sel,
    output logic                     take,
    output logic                     restart,
    output logic [2:0]               code_now,
    output logic [KW-1:0]            g_now,
    output logic [NPH-1:0][KW-1:0]   tap_k,
    output logic [NPH-1:0]           first_tap,
    output logic [NPH-1:0]           last_tap
);
    logic [2:0]     code_q, code_e, code_in;
    logic [KW-1:0]  g_q, g_e, mask_q, mask_e, step_e;
    logic [NPH-1:0] full_q, full_e;
    logic           live_q, sop_beat;
    logic [KW-1:0]  pos_e [NPH];

    assign sop_beat = in_valid && in_sop;
    assign code_in  = clamp_code(dec_sel);
    assign restart  = sop_beat && (!live_q || (code_in != code_q));
    assign take     = in_valid && (live_q || restart);
    assign mask_q   = KW'((8'd8 << code_q) - 8'd1);
    assign code_now = code_e;
    assign g_now    = g_q;

    // Next pulse context, and per-phase position, tap and flags for this beat.
    always_comb begin
        code_e = code_q;
        g_e    = g_q;
        full_e = full_q;
        if (restart) begin
            code_e = code_in;
            g_e    = '0;
            full_e = '0;
        end else if (sop_beat) begin
            g_e = (g_q + KW'(1)) & mask_q;
        end
        mask_e = KW'((8'd8 << code_e) - 8'd1);
        step_e = KW'(8'd2 << code_e);
        for (int j = 0; j < NPH; j++) begin
            pos_e[j]     = (g_e - KW'(step_e * KW'(j))) & mask_e;
            first_tap[j] = (pos_e[j] == '0);
            if (sop_beat && first_tap[j]) full_e[j] = 1'b1;
            last_tap[j]  = full_e[j] && (pos_e[j] == mask_e);
            tap_k[j]     = KW'(pos_e[j] << (3'd4 - code_e));
        end
    end

    // Hold the pulse context between beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            g_q    <= '0;
            full_q <= '0;
            live_q <= 1'b0;
        end else if (in_valid) begin
            code_q <= code_e;
            g_q    <= g_e;
            full_q <= full_e;
            live_q <= live_q || restart;
        end
    end
endmodule

// File: rtl/azpf_taper_rom.sv
// Taper lookup: returns the weight for a 7-bit taper index.
// Assumes: CW bits hold the taper maximum (1008) as an unsigned value.
module azpf_taper_rom
    import azpf_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic [KW-1:0] tap,
    output logic [CW-1:0] weight
);
    logic [CW-1:0] tbl [NTAP];

    // Constant table computed from the taper function.
    for (genvar i = 0; i < NTAP; i++) begin : g_tbl
        assign tbl[i] = CW'(taper(i));
    end

    assign weight = tbl[tap];
endmodule

// File: rtl/azpf_phase_acc.sv
// One phase of the integrate-and-dump bank: an I and a Q accumulator per
// range bin, updated with a read-modify-write in one cycle.
// Assumes: NB is a power of two; 'first' discards the stored sum so no clear
// pass is needed after a dump or after reset.
module azpf_phase_acc #(
    parameter int DW = 12,
    parameter int CW = 11,
    parameter int NB = 64,
    parameter int AW = DW + CW + 8,
    localparam int BW = $clog2(NB)
) (
    input  logic                 clk,
    input  logic                 en,
    input  logic [BW-1:0]        bin,
    input  logic                 first,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] x_q,
    input  logic [CW-1:0]        weight,
    output logic signed [AW-1:0] sum_i,
    output logic signed [AW-1:0] sum_q
);
    logic signed [AW-1:0] mem_i [NB];
    logic signed [AW-1:0] mem_q [NB];
    logic signed [AW-1:0] xe_i, xe_q, we;

    assign xe_i  = AW'(x_i);
    assign xe_q  = AW'(x_q);
    assign we    = AW'($signed({1'b0, weight}));
    assign sum_i = (first ? '0 : mem_i[bin]) + xe_i * we;
    assign sum_q = (first ? '0 : mem_q[bin]) + xe_q * we;

    // Write back the running sums of the bin just processed.
    always_ff @(posedge clk) begin
        if (en) begin
            mem_i[bin] <= sum_i;
            mem_q[bin] <= sum_q;
        end
    end
endmodule

// File: rtl/azpf_top.sv
// Azimuth decimating pre-filter: four overlapping weighted integrate-and-dump
// phases per range bin, selectable decimation M = 2..32.
// Pipeline: capture + control (stage 1), taper + accumulate + dump select
// (stage 2), round/saturate to output registers (stage 3).
// Assumes: each range bin appears at most once per pulse.
module azpf_top
    import azpf_pkg::*;
#(
    parameter int DW  = 12,
    parameter int CW  = 11,
    parameter int NB  = 64,
    parameter int SHB = 11,
    localparam int BW = $clog2(NB)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           dec_sel,
    input  logic                 in_valid,
    input  logic                 in_sop,
    input  logic [BW-1:0]        in_bin,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    output logic                 out_valid,
    output logic [BW-1:0]        out_bin,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);
    localparam int AW = DW + CW + 8;
    localparam logic signed [AW:0] OMAX = (AW+1)'((1 << (DW-1)) - 1);
    localparam logic signed [AW:0] OMIN = -OMAX - (AW+1)'(1);

    logic                   pc_take, pc_restart;
    logic [2:0]             pc_code;
    logic [KW-1:0]          pc_g;
    logic [NPH-1:0][KW-1:0] pc_k;
    logic [NPH-1:0]         pc_first, pc_last;

    azpf_pulse_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .dec_sel   (dec_sel),
        .take      (pc_take),
        .restart   (pc_restart),
        .code_now  (pc_code),
        .g_now     (pc_g),
        .tap_k     (pc_k),
        .first_tap (pc_first),
        .last_tap  (pc_last)
    );

    logic                   s1_v;
    logic [BW-1:0]          s1_bin;
    logic signed [DW-1:0]   s1_i, s1_q;
    logic [2:0]             s1_code;
    logic [NPH-1:0][KW-1:0] s1_k;
    logic [NPH-1:0]         s1_first, s1_last, s1_dump;

    // Stage 1: capture the sample with its per-phase context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            s1_bin   <= '0;
            s1_i     <= '0;
            s1_q     <= '0;
            s1_code  <= '0;
            s1_k     <= '0;
            s1_first <= '0;
            s1_last  <= '0;
        end else begin
            s1_v     <= pc_take;
            s1_bin   <= in_bin;
            s1_i     <= in_i;
            s1_q     <= in_q;
            s1_code  <= pc_code;
            s1_k     <= pc_k;
            s1_first <= pc_first;
            s1_last  <= pc_last;
        end
    end

    assign s1_dump = s1_v ? s1_last : '0;

    logic [CW-1:0]        w     [NPH];
    logic signed [AW-1:0] acc_i [NPH];
    logic signed [AW-1:0] acc_q [NPH];

    for (genvar j = 0; j < NPH; j++) begin : g_ph
        azpf_taper_rom #(.CW(CW)) u_rom (
            .tap    (s1_k[j]),
            .weight (w[j])
        );
        azpf_phase_acc #(.DW(DW), .CW(CW), .NB(NB), .AW(AW)) u_acc (
            .clk    (clk),
            .en     (s1_v),
            .bin    (s1_bin),
            .first  (s1_first[j]),
            .x_i    (s1_i),
            .x_q    (s1_q),
            .weight (w[j]),
            .sum_i  (acc_i[j]),
            .sum_q  (acc_q[j])
        );
    end

    logic signed [AW-1:0] dsel_i, dsel_q;

    // Pick the sum of the phase that completes its window on this beat.
    always_comb begin
        dsel_i = '0;
        dsel_q = '0;
        for (int j = 0; j < NPH; j++) begin
            if (s1_last[j]) begin
                dsel_i = acc_i[j];
                dsel_q = acc_q[j];
            end
        end
    end

    logic                 s2_v;
    logic [BW-1:0]        s2_bin;
    logic [2:0]           s2_code;
    logic signed [AW-1:0] s2_i, s2_q;

    // Stage 2: register the completed window sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_bin  <= '0;
            s2_code <= '0;
            s2_i    <= '0;
            s2_q    <= '0;
        end else begin
            s2_v    <= |s1_dump;
            s2_bin  <= s1_bin;
            s2_code <= s1_code;
            s2_i    <= dsel_i;
            s2_q    <= dsel_q;
        end
    end

    // Round half up by 2^s, then clamp to the signed output range.
    function automatic logic signed [DW-1:0] shrink(input logic signed [AW-1:0] a,
                                                    input logic [4:0] s);
        logic signed [AW:0] t;
        t = ($signed({a[AW-1], a}) + $signed((AW+1)'(1) << (s - 5'd1))) >>> s;
        if (t > OMAX)      t = OMAX;
        else if (t < OMIN) t = OMIN;
        return t[DW-1:0];
    endfunction

    logic [4:0] sh;
    assign sh = 5'(SHB) + {2'b00, s2_code};

    // Stage 3: scaled, saturated output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bin   <= '0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= s2_v;
            out_bin   <= s2_bin;
            out_i     <= shrink(s2_i, sh);
            out_q     <= shrink(s2_q, sh);
        end
    end
endmodule

// File: rtl/azpf_checker.sv
// Temporal checks for azpf_top, attached with bind.
module azpf_checker #(
    parameter int BW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [BW-1:0] in_bin,
    input logic          out_valid,
    input logic [BW-1:0] out_bin,
    input logic [3:0]    dump_vec,
    input logic          restart,
    input logic [6:0]    g_q
);
    // R9: every result follows a captured sample by three cycles
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

    // R2: result carries the bin of the completing sample
    p_bin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bin == $past(in_bin, 3)));

    // R3: at most one phase completes a window on any beat
    p_onedump_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dump_vec));

    // R7: a restart puts the pulse index back to zero
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && in_valid) |=> (g_q == 7'd0));

    // R8: reset silences the output
    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

bind azpf_top azpf_checker #(.BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_bin    (in_bin),
    .out_valid (out_valid),
    .out_bin   (out_bin),
    .dump_vec  (s1_dump),
    .restart   (pc_restart),
    .g_q       (pc_g)
);

// File: tb/azpf_top_tb.sv
// Scoreboard bench: the driver runs a reference model and queues the expected
// results; a monitor compares them with the outputs as they appear.
module azpf_top_tb;
    localparam int DW = 12;
    localparam int CW = 11;
    localparam int NB = 8;
    localparam int BW = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [2:0]           dec_sel = 3'd0;
    logic                 in_valid = 1'b0;
    logic                 in_sop = 1'b0;
    logic [BW-1:0]        in_bin = '0;
    logic signed [DW-1:0] in_i = '0;
    logic signed [DW-1:0] in_q = '0;
    logic                 out_valid;
    logic [BW-1:0]        out_bin;
    logic signed [DW-1:0] out_i, out_q;

    azpf_top #(.DW(DW), .CW(CW), .NB(NB), .SHB(11)) u_dut (
        .clk(clk), .rst_n(rst_n), .dec_sel(dec_sel), .in_valid(in_valid),
        .in_sop(in_sop), .in_bin(in_bin), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_bin(out_bin), .out_i(out_i), .out_q(out_q)
    );

    always #4 clk = ~clk;

    typedef struct {
        int     bin;
        int     vi;
        int     vq;
        longint cyc;
        int     tag;
    } exp_t;

    exp_t   sb[$];
    int     errors = 0;
    int     checks = 0;
    int     seen   = 0;
    longint cyc    = 0;
    bit     done   = 1'b0;

    // Reference model state.
    int     m_code = 0;
    int     m_g    = 0;
    bit     m_live = 1'b0;
    bit     m_full [4];
    longint m_ai [4][NB];
    longint m_aq [4][NB];
    int     tot    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int scale(input longint a, input int code);
        longint t;
        int sh;
        sh = 11 + code;
        t = (a + (longint'(1) <<< (sh - 1))) >>> sh;
        if (t > 2047)  t = 2047;
        if (t < -2048) t = -2048;
        return int'(t);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: compare each result with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            seen++;
            if (sb.size() == 0) begin
                check(1'b0, "R6", "unexpected output bin", longint'(out_bin), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (out_bin != BW'(e.bin) || int'(out_i) != e.vi ||
                    int'(out_q) != e.vq || cyc != e.cyc) begin
                    errors++;
                    $display("FAIL R%0d (R2 R4 R9) bin/i/q/cyc: actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                             e.tag, out_bin, out_i, out_q, cyc, e.bin, e.vi, e.vq, e.cyc);
                end
            end
        end
    end

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Drive one pulse across all bins, updating the model and the scoreboard.
    task automatic run_pulse(input int kind, input int tag, input int mid_sel);
        for (int b = 0; b < NB; b++) begin
            int xi, xq, span, mm;
            if (kind == 1) begin
                xi = 2047; xq = -2048;
            end else if (kind == 2) begin
                xi = ((tot % 2) == 0) ? (b * 150 - 600) : (600 - b * 90);
                xq = (b % 2 == 0) ? 300 : -700;
            end else begin
                xi = ((tot * 37 + b * 53) % 1001) - 500;
                xq = ((tot * 91 + b * 29) % 777) - 388;
            end
            if (b == 0) begin
                int code_in;
                code_in = (dec_sel > 3'd4) ? 4 : int'(dec_sel);
                if (!m_live || code_in != m_code) begin
                    m_code = code_in;
                    m_g    = 0;
                    m_live = 1'b1;
                    for (int j = 0; j < 4; j++) m_full[j] = 1'b0;
                end else begin
                    m_g = (m_g + 1) % (8 << m_code);
                end
            end
            span = 8 << m_code;
            mm   = 2 << m_code;
            for (int j = 0; j < 4; j++) begin
                int pos, k;
                longint wt;
                pos = (((m_g - j * mm) % span) + span) % span;
                if (b == 0 && pos == 0) m_full[j] = 1'b1;
                k  = pos * (32 / mm);
                wt = longint'((k * (127 - k)) / 4);
                if (pos == 0) begin
                    m_ai[j][b] = 0;
                    m_aq[j][b] = 0;
                end
                m_ai[j][b] += wt * xi;
                m_aq[j][b] += wt * xq;
                if (m_full[j] && pos == span - 1) begin
                    exp_t e;
                    e.bin = b;
                    e.vi  = scale(m_ai[j][b], m_code);
                    e.vq  = scale(m_aq[j][b], m_code);
                    e.cyc = cyc + 3;
                    e.tag = tag;
                    sb.push_back(e);
                end
            end
            in_valid = 1'b1;
            in_sop   = (b == 0);
            in_bin   = BW'(b);
            in_i     = DW'(xi);
            in_q     = DW'(xq);
            if (b == 3 && mid_sel >= 0) dec_sel = 3'(mid_sel);
            @(negedge clk);
        end
        tot++;
        idle(tot % 3);
    endtask

    function automatic int lines(input int p, input int m);
        return (p >= 4 * m) ? ((p - 4 * m) / m + 1) : 0;
    endfunction

    task automatic phase_lines(input int n, input int kind, input int tag,
                               input int p0, input int m, input string req);
        int s0;
        s0 = seen;
        repeat (n) run_pulse(kind, tag, -1);
        idle(5);
        check(seen - s0 == NB * (lines(p0 + n, m) - lines(p0, m)), req,
              "output count", seen - s0, NB * (lines(p0 + n, m) - lines(p0, m)));
        check(sb.size() == 0, req, "scoreboard left", sb.size(), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);

        // R3 R4: M = 2, 24 pulses from restart
        dec_sel = 3'd0;
        phase_lines(24, 0, 4, 0, 2, "R3");
        // R5: full-scale constant input drives both rails
        phase_lines(10, 1, 5, 24, 2, "R5");
        // R7: code change in mid-pulse leaves that pulse at M = 2
        run_pulse(0, 7, 1);
        idle(5);
        check(sb.size() == 0, "R7", "mid-pulse change", sb.size(), 0);
        // R7: the next start of pulse restarts at M = 4
        phase_lines(40, 2, 7, 0, 4, "R7");

        // R8: reset in mid-traffic, first pulse after is a restart
        rst_n = 1'b0;
        m_live = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8", "out_valid in mid reset", out_valid, 0);
        rst_n = 1'b1;
        dec_sel = 3'd4;
        // R6: no output from M = 32 before pulse 127
        phase_lines(127, 0, 6, 0, 32, "R6");
        phase_lines(13, 0, 4, 127, 32, "R3");
        // R1: code 7 aliases code 4, so no restart
        dec_sel = 3'd7;
        phase_lines(80, 0, 1, 140, 32, "R1");

        // R1: remaining codes
        dec_sel = 3'd2;
        phase_lines(40, 0, 1, 0, 8, "R1");
        dec_sel = 3'd3;
        phase_lines(70, 2, 1, 0, 16, "R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule